// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block adds two 16-bit unsigned operands and a single carry-in. It produces a 16-bit sum and a carry-out. It is purely combinational: it has no clock and no reset, and its outputs follow its inputs within one evaluation.

The operand width is split into four 4-bit slices. Each slice works out a propagate bit and a generate bit for every bit position. From these it forms its internal carries as fully expanded sums of products, so no carry waits on a neighbouring carry. Each slice also hands a group propagate and a group generate to a second lookahead stage. That stage uses the same expanded equations on the slice-level signals and the external carry-in to find the carry into each slice and the final carry-out.

Top module: `cla16_adder`

## Requirements
- R1: `sum_o` equals the low 16 bits of `a_i + b_i + cin_i` for every operand pair and both carry-in values.
- R2: `cout_o` equals bit 16 of the 17-bit result `a_i + b_i + cin_i`.
- R3: The carry entering each 4-bit slice (bit positions 4, 8 and 12) equals the carry out of the arithmetic sum of all lower bits and `cin_i`. A carry made in one slice therefore shows up in the first sum bit of the next slice.
- R4: With both operands zero and `cin_i` low, `sum_o` is 0x0000 and `cout_o` is 0.
- R5: With both operands 0xFFFF, the result is 0x1FFFE when `cin_i` is 0 and 0x1FFFF when `cin_i` is 1. With one operand 0xFFFF, the other 0x0000 and `cin_i` 1, the result is `sum_o` 0x0000 with `cout_o` 1.
- R6: When every bit position propagates and none generates (`a_i ^ b_i` all ones, `a_i & b_i` zero), `cout_o` equals `cin_i` and `sum_o` equals the bitwise inverse of `cin_i` replicated.
- R7: Swapping `a_i` and `b_i` leaves `sum_o` and `cout_o` unchanged.
- R8: A carry generated in the lowest slice reaches `cout_o` when all higher bit positions propagate (for example 0x0001 + 0xFFFF gives 0x0000 with carry-out 1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | First addend |
| b_i | input | 16 | Second addend |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Low 16 bits of the result |
| cout_o | output | 1 | Carry out of bit 15 |

## Verification
The two functions that can act at the same moment are the external carry-in and a full-width group propagate. When every slice reports group propagate, the carry-in has to pass through the second-level unit to `cout_o` along the same path that an in-slice generate uses. Operand pairs are chosen so that both are active together: all-ones plus zero with carry-in 1, alternating 0x5555/0xAAAA patterns with each carry-in value, and a low-slice generate under full propagate. The expected sum and carry-out come from a plain behavioural addition. The intermediate slice carries are checked against the sums of the lower bits.

// File: rtl/cla_pkg.sv
package cla_pkg;
    localparam int CLA_SLICE_W    = 4;
    localparam int CLA_NUM_SLICES = 4;
endpackage

// File: rtl/cla_lookahead.sv
// Generic one-level lookahead: carries into each position from propagate/generate
// vectors and a carry-in, each written as an expanded sum of products.
module cla_lookahead #(
    parameter int W = 4
) (
    input  logic [W-1:0] p_i,
    input  logic [W-1:0] g_i,
    input  logic         cin_i,
    output logic [W-1:0] c_o,
    output logic         grp_p_o,
    output logic         grp_g_o
);

    // Carry into position idx: cin through all lower propagates, OR each lower
    // generate through the propagates between it and idx.
    function automatic logic carry_at(input int idx, input logic [W-1:0] p,
                                      input logic [W-1:0] g, input logic cin);
        logic res;
        logic chain;
        logic term;
        chain = cin;
        for (int k = 0; k < W; k++) begin
            if (k < idx) chain = chain & p[k];
        end
        res = chain;
        for (int j = 0; j < W; j++) begin
            if (j < idx) begin
                term = g[j];
                for (int k = 0; k < W; k++) begin
                    if (k > j && k < idx) term = term & p[k];
                end
                res = res | term;
            end
        end
        return res;
    endfunction

    for (genvar i = 0; i < W; i++) begin : g_carry
        assign c_o[i] = carry_at(i, p_i, g_i, cin_i);
    end

    assign grp_p_o = &p_i;
    assign grp_g_o = carry_at(W, p_i, g_i, 1'b0);

endmodule

// File: rtl/cla_slice.sv
// One adder slice: per-bit propagate/generate, in-slice lookahead, group outputs.
module cla_slice #(
    parameter int W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         grp_p_o,
    output logic         grp_g_o
);

    logic [W-1:0] bit_p;
    logic [W-1:0] bit_g;
    logic [W-1:0] bit_c;

    for (genvar i = 0; i < W; i++) begin : g_pg
        assign bit_p[i] = a_i[i] ^ b_i[i];
        assign bit_g[i] = a_i[i] & b_i[i];
    end

    cla_lookahead #(.W(W)) u_look (
        .p_i     (bit_p),
        .g_i     (bit_g),
        .cin_i   (cin_i),
        .c_o     (bit_c),
        .grp_p_o (grp_p_o),
        .grp_g_o (grp_g_o)
    );

    assign sum_o = bit_p ^ bit_c;

endmodule

// File: rtl/cla16_adder.sv
// Two-level carry-lookahead adder: slices plus a second-level carry unit.
module cla16_adder #(
    parameter int SLICE_W    = cla_pkg::CLA_SLICE_W,
    parameter int NUM_SLICES = cla_pkg::CLA_NUM_SLICES,
    localparam int TOT_W     = SLICE_W * NUM_SLICES
) (
    input  logic [TOT_W-1:0] a_i,
    input  logic [TOT_W-1:0] b_i,
    input  logic             cin_i,
    output logic [TOT_W-1:0] sum_o,
    output logic             cout_o
);

    logic [NUM_SLICES-1:0] slice_p;
    logic [NUM_SLICES-1:0] slice_g;
    logic [NUM_SLICES-1:0] slice_cin;
    logic                  top_p;
    logic                  top_g;

    for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
        cla_slice #(.W(SLICE_W)) u_slice (
            .a_i     (a_i[s*SLICE_W +: SLICE_W]),
            .b_i     (b_i[s*SLICE_W +: SLICE_W]),
            .cin_i   (slice_cin[s]),
            .sum_o   (sum_o[s*SLICE_W +: SLICE_W]),
            .grp_p_o (slice_p[s]),
            .grp_g_o (slice_g[s])
        );
    end

    // Second level: same lookahead equations over slice-level signals.
    cla_lookahead #(.W(NUM_SLICES)) u_lcu (
        .p_i     (slice_p),
        .g_i     (slice_g),
        .cin_i   (cin_i),
        .c_o     (slice_cin),
        .grp_p_o (top_p),
        .grp_g_o (top_g)
    );

    assign cout_o = top_g | (top_p & cin_i);

endmodule

// File: rtl/cla16_adder_chk.sv
module cla16_adder_chk #(
    parameter int SLICE_W    = 4,
    parameter int NUM_SLICES = 4,
    localparam int TOT_W     = SLICE_W * NUM_SLICES
) (
    input logic [TOT_W-1:0]      a_i,
    input logic [TOT_W-1:0]      b_i,
    input logic                  cin_i,
    input logic [TOT_W-1:0]      sum_o,
    input logic                  cout_o,
    input logic [NUM_SLICES-1:0] slice_cin
);

    logic [TOT_W:0] ref_full;
    assign ref_full = {1'b0, a_i} + {1'b0, b_i} + {{TOT_W{1'b0}}, cin_i};

    always_comb begin
        AST_SUM_MATCH: assert (sum_o == ref_full[TOT_W-1:0]);  // R1
        AST_COUT_MATCH: assert (cout_o == ref_full[TOT_W]);     // R2
        if (a_i == '0 && b_i == '0 && !cin_i)
            AST_ZERO_RESULT: assert (sum_o == '0 && !cout_o);   // R4
        if ((a_i ^ b_i) == {TOT_W{1'b1}} && (a_i & b_i) == '0)
            AST_FULL_PROP: assert (cout_o == cin_i && sum_o == {TOT_W{~cin_i}});  // R6
    end

    always_comb begin
        for (int k = 0; k < NUM_SLICES; k++) begin
            logic [TOT_W:0] mask;
            logic [TOT_W:0] low_sum;
            mask    = ({{TOT_W{1'b0}}, 1'b1} << (k * SLICE_W)) - 1'b1;
            low_sum = ({1'b0, a_i} & mask) + ({1'b0, b_i} & mask) + {{TOT_W{1'b0}}, cin_i};
            AST_SLICE_CARRY: assert (slice_cin[k] == low_sum[k * SLICE_W]);  // R3
        end
    end

endmodule

bind cla16_adder cla16_adder_chk #(.SLICE_W(SLICE_W), .NUM_SLICES(NUM_SLICES)) u_chk (
    .a_i       (a_i),
    .b_i       (b_i),
    .cin_i     (cin_i),
    .sum_o     (sum_o),
    .cout_o    (cout_o),
    .slice_cin (slice_cin)
);

// File: tb/tb_cla16_adder.sv
module tb_cla16_adder;

    logic        clk = 1'b0;
    logic [15:0] a;
    logic [15:0] b;
    logic        cin;
    logic [15:0] sum;
    logic        cout;
    int          n_run  = 0;
    int          n_fail = 0;
    bit          done   = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    cla16_adder dut (
        .a_i    (a),
        .b_i    (b),
        .cin_i  (cin),
        .sum_o  (sum),
        .cout_o (cout)
    );

    // {a, b, cin, expected {cout,sum}}
    localparam int NV = 13;
    localparam logic [49:0] VEC [NV] = '{
        {16'h0000, 16'h0000, 1'b0, 17'h00000},
        {16'hFFFF, 16'h0000, 1'b1, 17'h10000},
        {16'hFFFF, 16'hFFFF, 1'b1, 17'h1FFFF},
        {16'hFFFF, 16'hFFFF, 1'b0, 17'h1FFFE},
        {16'h5555, 16'hAAAA, 1'b0, 17'h0FFFF},
        {16'h5555, 16'hAAAA, 1'b1, 17'h10000},
        {16'h000F, 16'h0001, 1'b0, 17'h00010},
        {16'h00FF, 16'h0001, 1'b0, 17'h00100},
        {16'h0FFF, 16'h0001, 1'b0, 17'h01000},
        {16'h8000, 16'h8000, 1'b0, 17'h10000},
        {16'h1234, 16'h4321, 1'b0, 17'h05555},
        {16'h7FFF, 16'h0000, 1'b1, 17'h08000},
        {16'h0001, 16'hFFFF, 1'b0, 17'h10000}
    };
    localparam string VTAG [NV] = '{
        "R4", "R5", "R5", "R5", "R6", "R6", "R3", "R3", "R3", "R2", "R1", "R3", "R8"
    };

    task automatic drive_check(input logic [15:0] ta, input logic [15:0] tb_op,
                               input logic tc, input logic [16:0] exp_v,
                               input string tag);
        @(posedge clk);
        a   = ta;
        b   = tb_op;
        cin = tc;
        @(negedge clk);
        n_run++;
        if ({cout, sum} !== exp_v) begin
            n_fail++;
            $display("FAIL %s: a=%h b=%h cin=%0d got %h expected %h",
                     tag, ta, tb_op, tc, {cout, sum}, exp_v);
        end
    endtask

    initial begin
        a = '0; b = '0; cin = 1'b0;
        // Initial state with idle inputs (R4)
        @(negedge clk);
        n_run++;
        if (sum !== 16'h0000 || cout !== 1'b0) begin
            n_fail++;
            $display("FAIL R4: got %h expected %h", {cout, sum}, 17'h0);
        end

        for (int i = 0; i < NV; i++) begin
            drive_check(VEC[i][49:34], VEC[i][33:18], VEC[i][17], VEC[i][16:0], VTAG[i]);
        end

        // Random operands against behavioural sum (R1, R2)
        for (int i = 0; i < 2000; i++) begin
            logic [15:0] ra;
            logic [15:0] rb;
            logic        rc;
            ra = 16'($urandom);
            rb = 16'($urandom);
            rc = 1'($urandom);
            drive_check(ra, rb, rc, {1'b0, ra} + {1'b0, rb} + {16'b0, rc}, "R1");
        end

        // Operand swap (R7)
        for (int i = 0; i < 200; i++) begin
            logic [15:0] ra;
            logic [15:0] rb;
            logic        rc;
            ra = 16'($urandom);
            rb = 16'($urandom);
            rc = 1'($urandom);
            drive_check(rb, ra, rc, {1'b0, ra} + {1'b0, rb} + {16'b0, rc}, "R7");
        end

        // Slice-boundary carries with one slice generating (R3)
        for (int s = 0; s < 4; s++) begin
            logic [15:0] ra;
            ra = 16'hF << (4 * s);
            drive_check(ra, 16'h1 << (4 * s), 1'b0, {1'b0, ra} + {1'b0, 16'h1 << (4 * s)}, "R3");
            drive_check(ra, 16'h0, 1'b1, {1'b0, ra} + 17'h1, "R3");
        end

        // Full propagate with generate in lowest slice (R8)
        drive_check(16'hFFF8, 16'h0008, 1'b0, 17'h10000, "R8");
        drive_check(16'hAAAB, 16'h5555, 1'b0, 17'h10000, "R8");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int c = 0; c < 100000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule